// File: doc/BRIEF.md
# Distributed-Arithmetic Subset-Sum Table with Parallel Refresh

This block holds, in registers, every nonzero subset sum of the most recent input samples of a small adaptive FIR filter (four taps by default). A distributed-arithmetic inner-product engine looks these sums up one weight bit slice at a time. Each slice is used as a table address whose bit j selects the sample that is j positions old.

When a new sample arrives with its valid strobe, a delay line shifts by one position. The whole table is refreshed on the same clock edge. Sums that involve only older samples are copied from the entry whose address is the new address shifted right by one bit. The entry for the lone newest sample is loaded directly. Only the sums that pair the newest sample with older ones need an adder, and these adders work in parallel. The design has no RAM and no reload sequencer. Several combinational read ports let more than one bit slice or engine look up sums in the same cycle.

Top module: `da_subset_table`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears every delay-line stage and every table entry to zero.
- R2: Address 0 is the empty subset and always reads as zero on every read port.
- R3: Table entry k equals the signed sum of the delay-line samples at ages j for which bit j of k is one. Age 0 is the newest sample.
- R4: On an edge with `smp_valid` high, the new sample becomes age 0 and each older sample moves one age up. Ages appear on `tap_data` with age j in bits [j*DATA_W +: DATA_W].
- R5: On an edge with `smp_valid` low, the delay line and the table keep their values, whatever `smp_data` carries.
- R6: Entries are signed, $clog2(TAPS) bits wider than the samples. Four full-scale samples of the same sign produce no overflow (4 x -32768 = -131072 and 4 x 32767 = 131068 at default widths).
- R7: Read port p uses address bits [p*TAPS +: TAPS] and returns data on bits [p*SUM_W +: SUM_W]. The ports work independently within the same cycle.
- R8: Reads are combinational. Before the edge that accepts a sample they return the old table. From that edge on they return the refreshed table.
- R9: Reset takes priority over a simultaneous valid sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample (byte) clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Accept `smp_data` at this edge |
| smp_data | input | DATA_W | New signed input sample |
| rd_addr | input | NUM_RD*TAPS | Per-port subset address (weight bit slice) |
| rd_data | output | NUM_RD*SUM_W | Per-port signed subset sum |
| tap_data | output | TAPS*DATA_W | Delay-line samples, age 0 in the low field |

## Verification
A table refresh and a lookup can fall in the same cycle. While a sample is presented with its strobe, the read ports are addressed, so a lookup overlaps the refresh. The bench reads once just before the edge and expects the old sums, then reads after the edge and expects the new ones. Reset together with a valid sample is also provoked, and the bench expects all-zero results.

// File: rtl/da_tbl_pkg.sv
package da_tbl_pkg;

   // Width of a subset sum: enough guard bits for TAPS terms.
   function automatic int sum_width(input int data_w, input int taps);
      return data_w + $clog2(taps);
   endfunction

   // Number of table entries, empty subset included.
   function automatic int entry_count(input int taps);
      return 1 << taps;
   endfunction

   // Entries that need an adder: odd addresses above one.
   function automatic int adder_count(input int taps);
      return (1 << (taps - 1)) - 1;
   endfunction

endpackage

// File: rtl/da_tap_line.sv
module da_tap_line #(
   parameter int DATA_W = 16,
   parameter int TAPS   = 4
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   shift_en,
   input  logic [DATA_W-1:0]      din,
   output logic [TAPS*DATA_W-1:0] taps_o
);

   logic [DATA_W-1:0] stage_q [TAPS];

   generate
      for (genvar j = 0; j < TAPS; j++) begin : g_stage
         if (j == 0) begin : g_head
            always_ff @(posedge clk) begin
               if (rst)           stage_q[j] <= '0;
               else if (shift_en) stage_q[j] <= din;
            end
         end else begin : g_body
            always_ff @(posedge clk) begin
               if (rst)           stage_q[j] <= '0;
               else if (shift_en) stage_q[j] <= stage_q[j-1];
            end
         end
         assign taps_o[j*DATA_W +: DATA_W] = stage_q[j];
      end
   endgenerate

   // R4: a valid sample lands at age 0 and age 0 moves to age 1
   a_r4_tap_shift : assert property (@(posedge clk) disable iff (rst)
      shift_en |=> (taps_o[DATA_W-1:0] == $past(din)) &&
                   (taps_o[2*DATA_W-1:DATA_W] == $past(taps_o[DATA_W-1:0])));

endmodule

// File: rtl/da_table_bank.sv
module da_table_bank #(
   parameter int DATA_W = 16,
   parameter int TAPS   = 4,
   parameter int SUM_W  = da_tbl_pkg::sum_width(DATA_W, TAPS)
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        load_en,
   input  logic [DATA_W-1:0]           din,
   output logic [(1<<TAPS)*SUM_W-1:0]  tbl_o
);

   localparam int ENTRIES = da_tbl_pkg::entry_count(TAPS);
   localparam int N_ADD   = da_tbl_pkg::adder_count(TAPS);

   logic [SUM_W-1:0] ent_q [1:ENTRIES-1];
   logic [SUM_W-1:0] din_wide;

   assign din_wide = {{(SUM_W-DATA_W){din[DATA_W-1]}}, din};

   if (SUM_W < DATA_W + $clog2(TAPS)) begin : g_bad_width
      $error("da_table_bank: SUM_W too narrow for %0d terms", TAPS);
   end
   if (N_ADD != ENTRIES/2 - 1) begin : g_bad_adders
      $error("da_table_bank: adder count mismatch");
   end

   assign tbl_o[SUM_W-1:0] = '0;

   generate
      for (genvar k = 1; k < ENTRIES; k++) begin : g_ent
         logic [SUM_W-1:0] nxt;
         if (k == 1) begin : g_single
            assign nxt = din_wide;
         end else if ((k % 2) == 0) begin : g_carry
            assign nxt = ent_q[k/2];
         end else begin : g_add
            assign nxt = din_wide + ent_q[k/2];
         end

         always_ff @(posedge clk) begin
            if (rst)          ent_q[k] <= '0;
            else if (load_en) ent_q[k] <= nxt;
         end

         assign tbl_o[k*SUM_W +: SUM_W] = ent_q[k];
      end
   endgenerate

   // R5: without a valid sample the table is frozen
   a_r5_hold_idle : assert property (@(posedge clk) disable iff (rst)
      !load_en |=> $stable(tbl_o));

   // R3: the full-set entry grows by the new sample minus the sample that leaves
   a_r3_full_set_step : assert property (@(posedge clk) disable iff (rst)
      load_en |=> (tbl_o[(ENTRIES-1)*SUM_W +: SUM_W] ==
                   $past(din_wide) + $past(tbl_o[(ENTRIES/2-1)*SUM_W +: SUM_W])));

endmodule

// File: rtl/da_read_port.sv
module da_read_port #(
   parameter int TAPS  = 4,
   parameter int SUM_W = 18
) (
   input  logic [TAPS-1:0]               addr,
   input  logic [(1<<TAPS)*SUM_W-1:0]    tbl,
   output logic [SUM_W-1:0]              data
);

   localparam int ENTRIES = 1 << TAPS;

   logic [SUM_W-1:0] row [ENTRIES];

   generate
      for (genvar k = 0; k < ENTRIES; k++) begin : g_row
         assign row[k] = tbl[k*SUM_W +: SUM_W];
      end
   endgenerate

   assign data = row[addr];

   // R2: empty subset reads zero
   always_comb begin
      if (addr == '0) a_r2_empty_subset : assert (data == '0);
   end

endmodule

// File: rtl/da_subset_table.sv
module da_subset_table #(
   parameter int DATA_W = 16,
   parameter int TAPS   = 4,
   parameter int NUM_RD = 2,
   parameter int SUM_W  = da_tbl_pkg::sum_width(DATA_W, TAPS)
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      smp_valid,
   input  logic [DATA_W-1:0]         smp_data,
   input  logic [NUM_RD*TAPS-1:0]    rd_addr,
   output logic [NUM_RD*SUM_W-1:0]   rd_data,
   output logic [TAPS*DATA_W-1:0]    tap_data
);

   localparam int ENTRIES = da_tbl_pkg::entry_count(TAPS);

   if (TAPS < 2 || TAPS > 8) begin : g_bad_taps
      $error("da_subset_table: TAPS must be 2..8, got %0d", TAPS);
   end
   if (NUM_RD < 1) begin : g_bad_ports
      $error("da_subset_table: NUM_RD must be at least 1");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("da_subset_table: DATA_W must be at least 2");
   end

   logic [ENTRIES*SUM_W-1:0] tbl_w;

   da_tap_line #(.DATA_W(DATA_W), .TAPS(TAPS)) u_line (
      .clk(clk), .rst(rst), .shift_en(smp_valid), .din(smp_data), .taps_o(tap_data)
   );

   da_table_bank #(.DATA_W(DATA_W), .TAPS(TAPS), .SUM_W(SUM_W)) u_bank (
      .clk(clk), .rst(rst), .load_en(smp_valid), .din(smp_data), .tbl_o(tbl_w)
   );

   generate
      for (genvar p = 0; p < NUM_RD; p++) begin : g_port
         da_read_port #(.TAPS(TAPS), .SUM_W(SUM_W)) u_rd (
            .addr(rd_addr[p*TAPS +: TAPS]),
            .tbl (tbl_w),
            .data(rd_data[p*SUM_W +: SUM_W])
         );
      end

      // R3: single-sample entries agree with the separately held delay line
      for (genvar j = 0; j < TAPS; j++) begin : g_single_chk
         a_r3_single_tap : assert property (@(posedge clk) disable iff (rst)
            tbl_w[(1<<j)*SUM_W +: SUM_W] ==
            {{(SUM_W-DATA_W){tap_data[j*DATA_W+DATA_W-1]}}, tap_data[j*DATA_W +: DATA_W]});
      end
   endgenerate

   // R1, R9: reset clears the line and the full-set entry even with a valid sample
   a_r1_reset_clear : assert property (@(posedge clk)
      rst |=> (tap_data == '0) && (tbl_w[(ENTRIES-1)*SUM_W +: SUM_W] == '0));

endmodule

// File: tb/test_da_subset_table.sv
module test_da_subset_table;

   localparam int CLK_P = 10;
   localparam int DW    = 16;
   localparam int TP    = 4;
   localparam int SW    = 18;
   localparam int NRD   = 2;

   logic               clk = 1'b0;
   logic               rst = 1'b1;
   logic               vld = 1'b0;
   logic [DW-1:0]      din = '0;
   logic [NRD*TP-1:0]  ra  = '0;
   wire  [NRD*SW-1:0]  rd;
   wire  [TP*DW-1:0]   tp;

   always #(CLK_P/2) clk = ~clk;

   da_subset_table #(.DATA_W(DW), .TAPS(TP), .NUM_RD(NRD), .SUM_W(SW)) i_da_subset_table (
      .clk(clk), .rst(rst), .smp_valid(vld), .smp_data(din),
      .rd_addr(ra), .rd_data(rd), .tap_data(tp)
   );

   typedef struct {
      int    a0;
      int    a1;
      int    e0;
      int    e1;
      int    t[TP];
      string tag;
   } exp_t;

   exp_t sbq[$];
   int   model[TP];
   int   checks = 0;
   int   fails  = 0;

   function automatic int mexp(int addr);
      int s = 0;
      for (int j = 0; j < TP; j++) if (((addr >> j) & 1) == 1) s += model[j];
      return s;
   endfunction

   function automatic int port_val(int p);
      logic signed [SW-1:0] v;
      v = rd[p*SW +: SW];
      return int'(v);
   endfunction

   function automatic int tap_val(int j);
      logic signed [DW-1:0] v;
      v = tp[j*DW +: DW];
      return int'(v);
   endfunction

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // driver: applies one cycle of stimulus and queues what must follow the edge
   task automatic step(bit r, bit v, int d, int a0, int a1, string tag, bit pre);
      exp_t it;
      @(negedge clk);
      rst = r;
      vld = v;
      din = d[DW-1:0];
      ra  = {a1[TP-1:0], a0[TP-1:0]};
      #1;
      if (pre) chk({tag, " R8 pre-edge old sum"}, port_val(0), mexp(a0));
      if (r) begin
         for (int j = 0; j < TP; j++) model[j] = 0;
      end else if (v) begin
         for (int j = TP-1; j > 0; j--) model[j] = model[j-1];
         model[0] = d;
      end
      it.a0 = a0; it.a1 = a1;
      it.e0 = mexp(a0); it.e1 = mexp(a1);
      for (int j = 0; j < TP; j++) it.t[j] = model[j];
      it.tag = tag;
      sbq.push_back(it);
   endtask

   // monitor: compares after each active edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sbq.size() > 0) begin
            exp_t it;
            it = sbq.pop_front();
            chk({it.tag, " port0"}, port_val(0), it.e0);
            chk({it.tag, " port1 R7"}, port_val(1), it.e1);
            for (int j = 0; j < TP; j++) chk({it.tag, " R4 tap"}, tap_val(j), it.t[j]);
         end
      end
   end

   initial begin
      #(CLK_P * 200000);
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      for (int j = 0; j < TP; j++) model[j] = 0;
      // R1 reset state
      step(1, 0, 0, 15, 0, "R1 reset", 0);
      step(1, 0, 0, 5, 10, "R1 reset", 0);
      // R4/R8 fill with mixed signs
      step(0, 1, 100,   1, 0,  "R4 R8 fill1", 1);
      step(0, 1, -7,    3, 2,  "R4 R8 fill2", 1);
      step(0, 1, 300,   7, 5,  "R4 R8 fill3", 1);
      step(0, 1, -2000, 15, 10, "R4 R8 fill4", 1);
      // R5 idle with noisy data
      step(0, 0, 12345, 15, 9, "R5 idle hold", 1);
      step(0, 0, -1,    13, 6, "R5 idle hold", 1);
      // R3 every address, R2 included at address 0
      for (int a = 0; a < 16; a += 2) step(0, 0, 0, a, a + 1, "R3 R2 sweep", 0);
      // R7 independent ports while a sample enters
      step(0, 1, 5, 6, 11, "R7 R8 dual read", 1);
      // R6 full-scale negative then positive
      for (int i = 0; i < 4; i++) step(0, 1, -32768, 15, 12, "R6 neg full scale", 0);
      for (int i = 0; i < 4; i++) step(0, 1, 32767, 15, 14, "R6 pos full scale", 0);
      // R9 reset beats a valid sample
      step(1, 1, 555, 15, 1, "R9 reset priority", 0);
      step(0, 0, 0, 0, 0, "R2 empty after reset", 0);
      step(0, 1, -9, 1, 0, "R2 empty subset", 0);
      step(0, 0, 0, 0, 1, "R2 empty subset", 0);
      @(negedge clk);
      @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule